// File: doc/BRIEF.md
# Multi-core watchdog pause controller

This block is a shared register file that sits next to a set of per-core watchdog timers. Each core has its own group of registers on a simple memory-mapped bus. Through that group, software can hold the core's watchdog in a paused state. It can also arm a core reset that fires when that watchdog reports its second timeout. Software can read a fixed locator word that tells it where the core's watchdog registers live, along with a version number.

Pausing needs a deliberate action: software must write a magic code. A write of one to the paused bit releases the pause. The reset-arm bit can only be set by software. Hardware drops it while the core is powered down. The block drives one pause line and one reset-request line per core. It observes one second-timeout line, one power-active line and one local reset line per core.

Top module: `wdt_pause_ctrl`

## Requirements
- R1: Core x's register group starts at byte address 0x20*x. Within a group, the control word is at offset 0x04 and the locator word is at 0x08. Read data appears on `bus_rdata` in the cycle after `bus_ren` is sampled, and it holds until the next read.
- R2: Writing 0x76 into control bits 7:0 sets the paused bit (bit 8). The core's pause output follows the paused bit. Bits 7:0 always read as zero.
- R3: Writing any value other than 0x76 into bits 7:0, with bit 8 at zero, leaves the paused bit unchanged.
- R4: Writing 1 to bit 8 clears the paused bit and releases the pause output. Writing 0 to bit 8 does nothing. If a single write carries both 0x76 and bit 8 set, the bit ends up set.
- R5: Control bit 9 (reset arm) is set by writing 1 to it. Writing 0 to it has no effect.
- R6: While a core's power-active input is low, its reset-arm bit reads 0 and writes of 1 to it are ignored.
- R7: With reset arm set, a rising edge on a core's second-timeout input produces a one-cycle reset request for that core in the cycle after the edge is sampled. With reset arm clear, no request is produced.
- R8: The locator word for core x reads 0x78300 + 0x100*x in bits 20:0 and zero in bits 23:21 (version) and above. Writes to it are ignored.
- R9: While a core's active-low local reset is low, that core's paused and reset-arm bits are held at 0.
- R10: Reads of unmapped offsets or groups return zero, and writes to them change nothing. The synchronous active-high reset clears all state.
- R11: A write to one core's group leaves every other core's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_pwr_on | input | 3 | Per-core power-active |
| core_lrst_n | input | 3 | Per-core local reset, active low |
| wdt_sto | input | 3 | Per-core second-timeout from the watchdog |
| wdt_pause | output | 3 | Per-core pause to the watchdog |
| core_rst_req | output | 3 | Per-core reset request pulse |

## Verification
The assertions assume the following about the inputs:
- The bus is never driven with a write and a read in the same cycle.
- Power-active and local reset are plain levels sampled on the clock.
- A second-timeout level may stay high for any number of cycles, but only its rising edge counts.

The directed stimulus changes every input at the falling edge and issues one bus access at a time. It toggles power-active, local reset and second-timeout only between accesses. It holds second-timeout high for several cycles so that the single-pulse rule is exercised.

// File: rtl/wdtpc_pkg.sv
package wdtpc_pkg;
  localparam int GRP_W      = 5;
  localparam logic [4:0] OFS_CTRL = 5'h04;
  localparam logic [4:0] OFS_PTR  = 5'h08;
  localparam logic [7:0] PCODE    = 8'h76;
  localparam int BIT_PAUSED = 8;
  localparam int BIT_ARM    = 9;
  localparam int LOC_W      = 21;

  function automatic logic [31:0] loc_word(input int idx,
                                           input logic [LOC_W-1:0] base,
                                           input logic [LOC_W-1:0] step);
    logic [LOC_W-1:0] v;
    v = base + LOC_W'(step * idx);
    return {8'h00, 3'b000, v};
  endfunction
endpackage

// File: rtl/wdtpc_decode.sv
module wdtpc_decode
  import wdtpc_pkg::*;
#(
  parameter int NCORE  = 3,
  parameter int ADDR_W = $clog2(NCORE) + GRP_W,
  localparam int IDX_W = ADDR_W - GRP_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output logic [IDX_W-1:0]  idx,
  output logic              hit_ctrl,
  output logic              hit_loc,
  output logic [NCORE-1:0]  wr_ctrl
);
  logic in_range;

  assign idx      = addr[ADDR_W-1:GRP_W];
  assign in_range = (int'(idx) < NCORE);
  assign hit_ctrl = in_range && (addr[GRP_W-1:0] == OFS_CTRL);
  assign hit_loc  = in_range && (addr[GRP_W-1:0] == OFS_PTR);

  for (genvar c = 0; c < NCORE; c++) begin : g_wr
    assign wr_ctrl[c] = wen && hit_ctrl && (int'(idx) == c);
  end
endmodule

// File: rtl/wdtpc_core.sv
module wdtpc_core
  import wdtpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lrst_n,
  input  logic       pwr_on,
  input  logic       wr,
  input  logic [9:0] wdata,
  input  logic       sto,
  output logic       paused_o,
  output logic       arm_o,
  output logic       rst_req_o
);
  logic sto_d;
  logic code_hit;

  assign code_hit = (wdata[7:0] == PCODE);

  always_ff @(posedge clk) begin
    if (rst || !lrst_n) begin
      paused_o <= 1'b0;
    end else if (wr && code_hit) begin
      paused_o <= 1'b1;
    end else if (wr && wdata[BIT_PAUSED]) begin
      paused_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !lrst_n || !pwr_on) begin
      arm_o <= 1'b0;
    end else if (wr && wdata[BIT_ARM]) begin
      arm_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sto_d     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      sto_d     <= sto;
      rst_req_o <= arm_o && sto && !sto_d;
    end
  end

  a_r2_code_sets: assert property (@(posedge clk) disable iff (rst)
    (wr && code_hit && lrst_n) |=> paused_o);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[BIT_PAUSED] && !code_hit && lrst_n) |=> !paused_o);
  a_r3_other_code_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[BIT_PAUSED] && !code_hit && lrst_n) |=> $stable(paused_o));
  a_r6_power_drop: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> !arm_o);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  a_r7_needs_arm: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(arm_o) && $past(sto));
  a_r9_local_reset: assert property (@(posedge clk) disable iff (rst)
    !lrst_n |=> (!paused_o && !arm_o));
endmodule

// File: rtl/wdt_pause_ctrl.sv
module wdt_pause_ctrl
  import wdtpc_pkg::*;
#(
  parameter int NCORE = 3,
  parameter logic [20:0] LOC_BASE = 21'h78300,
  parameter logic [20:0] LOC_STEP = 21'h00100,
  localparam int ADDR_W = $clog2(NCORE) + GRP_W,
  localparam int IDX_W  = ADDR_W - GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCORE-1:0]  core_pwr_on,
  input  logic [NCORE-1:0]  core_lrst_n,
  input  logic [NCORE-1:0]  wdt_sto,
  output logic [NCORE-1:0]  wdt_pause,
  output logic [NCORE-1:0]  core_rst_req
);
  logic [IDX_W-1:0] idx;
  logic             hit_ctrl;
  logic             hit_loc;
  logic [NCORE-1:0] wr_ctrl;
  logic [NCORE-1:0] arm;
  logic [31:0]      rd_word;

  wdtpc_decode #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wen(bus_wen), .idx(idx),
    .hit_ctrl(hit_ctrl), .hit_loc(hit_loc), .wr_ctrl(wr_ctrl)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    wdtpc_core u_core (
      .clk(clk), .rst(rst),
      .lrst_n(core_lrst_n[c]), .pwr_on(core_pwr_on[c]),
      .wr(wr_ctrl[c]), .wdata(bus_wdata[9:0]), .sto(wdt_sto[c]),
      .paused_o(wdt_pause[c]), .arm_o(arm[c]), .rst_req_o(core_rst_req[c])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (int'(idx) == c) begin
        if (hit_ctrl) rd_word = {22'b0, arm[c], wdt_pause[c], 8'h00};
        else if (hit_loc) rd_word = loc_word(c, LOC_BASE, LOC_STEP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_word;
  end

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && !hit_ctrl && !hit_loc) |=> (bus_rdata == 32'h0));
  a_r2_code_field_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && hit_ctrl) |=> (bus_rdata[7:0] == 8'h00));
  a_r8_version_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && hit_loc) |=> (bus_rdata[31:21] == 11'h0));
endmodule

// File: tb/wdt_pause_ctrl_test.sv
module wdt_pause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  bus_addr;
  logic        bus_wen, bus_ren;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  core_pwr_on, core_lrst_n, wdt_sto;
  logic [2:0]  wdt_pause, core_rst_req;
  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  wdt_pause_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_pwr_on(core_pwr_on), .core_lrst_n(core_lrst_n), .wdt_sto(wdt_sto),
    .wdt_pause(wdt_pause), .core_rst_req(core_rst_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [6:0] ctl(input int c); return 7'(c * 32 + 4); endfunction
  function automatic logic [6:0] loc(input int c); return 7'(c * 32 + 8); endfunction

  task automatic t_reset();
    check("R10 reset pause", {29'b0, wdt_pause}, 32'h0);
    check("R10 reset req", {29'b0, core_rst_req}, 32'h0);
    check("R10 reset rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_locator();
    for (int c = 0; c < 3; c++) begin
      rd(loc(c), rv);
      check("R8 locator", rv, 32'h78300 + 32'h100 * c);
    end
    wr(loc(1), 32'hFFFF_FFFF);
    rd(loc(1), rv);
    check("R8 locator write ignored", rv, 32'h78400);
    rd(ctl(2), rv);
    check("R1 ctrl reads idle", rv, 32'h0);
  endtask

  task automatic t_pause_set();
    wr(ctl(1), 32'h76);
    check("R2 pause output", {29'b0, wdt_pause}, 32'h2);
    rd(ctl(1), rv);
    check("R2 paused bit, code reads 0", rv, 32'h100);
    check("R11 other cores untouched", {29'b0, wdt_pause}, 32'h2);
  endtask

  task automatic t_bad_code();
    wr(ctl(0), 32'h75);
    check("R3 bad code no set", {29'b0, wdt_pause}, 32'h2);
    wr(ctl(1), 32'h77);
    check("R3 bad code keeps set", {29'b0, wdt_pause}, 32'h2);
  endtask

  task automatic t_clear();
    wr(ctl(1), 32'h000);
    check("R4 write 0 keeps", {29'b0, wdt_pause}, 32'h2);
    wr(ctl(1), 32'h100);
    check("R4 w1c clears", {29'b0, wdt_pause}, 32'h0);
    wr(ctl(2), 32'h176);
    check("R4 set wins over clear", {29'b0, wdt_pause}, 32'h4);
    wr(ctl(2), 32'h100);
    check("R4 clear core2", {29'b0, wdt_pause}, 32'h0);
  endtask

  task automatic t_arm();
    wr(ctl(0), 32'h200);
    rd(ctl(0), rv);
    check("R5 arm set", rv, 32'h200);
    wr(ctl(0), 32'h000);
    rd(ctl(0), rv);
    check("R5 write 0 keeps arm", rv, 32'h200);
    rd(ctl(1), rv);
    check("R11 arm core1 clear", rv, 32'h0);
  endtask

  task automatic t_req();
    wdt_sto[0] = 1'b1;
    @(negedge clk);
    check("R7 pulse", {29'b0, core_rst_req}, 32'h1);
    @(negedge clk);
    check("R7 single cycle", {29'b0, core_rst_req}, 32'h0);
    @(negedge clk);
    wdt_sto[0] = 1'b0;
    wdt_sto[1] = 1'b1;
    @(negedge clk);
    check("R7 disarmed no req", {29'b0, core_rst_req}, 32'h0);
    wdt_sto[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_power();
    core_pwr_on[0] = 1'b0;
    @(negedge clk);
    rd(ctl(0), rv);
    check("R6 arm cleared on power off", rv, 32'h0);
    wr(ctl(0), 32'h200);
    rd(ctl(0), rv);
    check("R6 arm write ignored", rv, 32'h0);
    core_pwr_on[0] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_lrst();
    wr(ctl(2), 32'h276);
    check("R9 pre pause", {29'b0, wdt_pause}, 32'h4);
    core_lrst_n[2] = 1'b0;
    @(negedge clk);
    check("R9 pause cleared", {29'b0, wdt_pause}, 32'h0);
    wr(ctl(2), 32'h276);
    core_lrst_n[2] = 1'b1;
    rd(ctl(2), rv);
    check("R9 bits held in reset", rv, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(ctl(0), 32'h76);
    rd(7'h05, rv);
    check("R10 unmapped offset", rv, 32'h0);
    rd(7'h60, rv);
    check("R10 unmapped group", rv, 32'h0);
    rd(7'h64, rv);
    check("R10 unmapped group ctrl", rv, 32'h0);
    wr(7'h00, 32'h100);
    wr(7'h0C, 32'h100);
    wr(7'h64, 32'h100);
    check("R10 unmapped writes ignored", {29'b0, wdt_pause}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wen = 1'b0; bus_ren = 1'b0; bus_wdata = '0;
    core_pwr_on = 3'b111; core_lrst_n = 3'b111; wdt_sto = 3'b000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_locator();
    t_pause_set();
    t_bad_code();
    t_clear();
    t_arm();
    t_req();
    t_power();
    t_lrst();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule